// File: doc/BRIEF.md
# Interrupt Source Controller

This block manages a parameterised set of interrupt sources. Each source is fixed at build time as either a level source or a message (edge) source. Each source holds a destination server, a priority and a saved priority. A priority of all ones (0xFF) masks the source. The block watches one input line per source. It raises delivery requests toward a single presentation unit, and each request carries the global source number (a base offset plus the local index), the priority and the server.

The presentation unit answers each request with accept or reject. Later it can send reject or end-of-interrupt (EOI) notices, addressed by global number. It can also ask for a resend, which scans every source in index order, one source at a time. Per-source status bits drive redelivery after a reject, after an EOI or after a source is unmasked. These bits are: the registered line value, sent (level), rejected (message) and held (message, masked while an event arrived). A configuration write port sets server, priority and saved priority, and a combinational readback returns the fields of the source that the port addresses.

Top module: `intr_src_ctl`

## Requirements
- R1: After reset no request is raised and no scan runs. Every priority and saved priority reads 0xFF and every server reads 0. All status bits are clear. The level or message type of each source survives the reset.
- R2: A rising edge on an unmasked message source raises one request with number BASE+index, the source's priority and the source's server.
- R3: A rising edge on a masked message source raises no request and marks the source held. A configuration write with a priority other than 0xFF then releases exactly one request. A write with priority 0xFF keeps the source held.
- R4: A reject of a message source marks it rejected. The reject can be a notice with ntc_eoi=0 or a rejected response to its request. The next resend clears the mark and redelivers the source only if its priority is not 0xFF.
- R5: A level source is delivered, and marked sent, when its priority is not 0xFF, its line is high and it is not already sent. While it is sent, line changes raise no further request.
- R6: A reject (ntc_eoi=0) or an EOI (ntc_eoi=1) of a level source clears its sent mark and raises no request by itself. The next re-evaluation, such as a resend, redelivers the source if its line is still high.
- R7: A configuration write re-evaluates a level source. Unmasking a level source whose line is high delivers it.
- R8: An EOI addressed to a message source leaves its status unchanged.
- R9: A notice whose number lies outside BASE to BASE+N_SRC-1 changes nothing.
- R10: A request keeps its number, priority and server stable until an accept or reject arrives. After that response the valid signal stays low for at least one cycle.
- R11: When several sources are pending, the lowest index is requested first. A resend scan visits the sources in index order and waits for each delivery to be answered before it moves to the next source.
- R12: A configuration write that unmasks a held message source, in the same cycle as a new edge on that source, raises exactly one request.
- R13: From the cycle after a configuration write, the readback for the addressed index returns the written server, priority and saved priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_line | input | N_SRC | Interrupt input line per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index for write and readback |
| cfg_server | input | SERVER_W | Server to write |
| cfg_prio | input | 8 | Priority to write (0xFF masks) |
| cfg_saved | input | 8 | Saved priority to write |
| cfg_rd_server | output | SERVER_W | Server of source cfg_idx |
| cfg_rd_prio | output | 8 | Priority of source cfg_idx |
| cfg_rd_saved | output | 8 | Saved priority of source cfg_idx |
| ntc_valid | input | 1 | Notice strobe from the presentation unit |
| ntc_eoi | input | 1 | 1 = EOI, 0 = reject |
| ntc_num | input | SRC_W | Global source number of the notice |
| resend_req | input | 1 | Start a resend scan (ignored while a scan runs) |
| req_valid | output | 1 | Delivery request valid |
| req_num | output | SRC_W | Global source number of the request |
| req_server | output | SERVER_W | Destination server |
| req_prio | output | 8 | Priority of the request |
| rsp_ack | input | 1 | Presentation unit accepted the request |
| rsp_nak | input | 1 | Presentation unit rejected the request |
| scan_busy | output | 1 | Resend scan in progress |

## Verification
A configuration write and an input edge can land on the same message source in the same cycle. If the source is held, the unmasking write and the new edge each want to deliver, and the block must merge them into a single request. The bench drives both strobes in one cycle on a held source. Its reference model applies the write before the edge and merges deliveries that are still pending. A second request, or a missing one, is reported as a mismatch. Simultaneous edges on several lines are judged in the same way, against lowest-index-first ordering.

// File: rtl/isc_pkg.sv
package isc_pkg;

    localparam int PRIO_W = 8;
    typedef logic [PRIO_W-1:0] prio_t;
    localparam prio_t PRIO_OFF = '1;

    // per-source status flags
    typedef struct packed {
        logic line_q;    // registered input line
        logic sent;      // level: delivered, awaiting EOI/reject
        logic rejected;  // message: bounced, waits for resend
        logic held;      // message: arrived while masked
    } src_stat_t;

    typedef enum logic [1:0] {
        SCAN_IDLE  = 2'd0,
        SCAN_VISIT = 2'd1,
        SCAN_WAIT  = 2'd2
    } scan_st_t;

    // index of the lowest set bit (0 when none set)
    function automatic int unsigned lowest_set(input logic [63:0] v);
        int unsigned r;
        r = 0;
        for (int i = 63; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/isc_slot.sv
module isc_slot
    import isc_pkg::*;
#(
    parameter bit IS_LEVEL = 1'b0,
    parameter int SERVER_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                line,
    input  logic                cfg_hit,
    input  logic [SERVER_W-1:0] cfg_server,
    input  prio_t               cfg_prio,
    input  prio_t               cfg_saved,
    input  logic                rej_hit,
    input  logic                eoi_hit,
    input  logic                scan_hit,
    input  logic                issue_hit,
    output logic                want,
    output prio_t               prio,
    output prio_t               saved,
    output logic [SERVER_W-1:0] server
);

    prio_t               prio_q, prio_n, saved_q, saved_n;
    logic [SERVER_W-1:0] server_q, server_n;
    src_stat_t           st_q, st_n;
    logic                want_q, deliver, open_n;

    always_comb begin
        prio_n   = cfg_hit ? cfg_prio   : prio_q;
        saved_n  = cfg_hit ? cfg_saved  : saved_q;
        server_n = cfg_hit ? cfg_server : server_q;
        open_n   = (prio_n != PRIO_OFF);
        st_n        = st_q;
        st_n.line_q = line;
        deliver     = 1'b0;
        if (IS_LEVEL) begin
            if (rej_hit || eoi_hit) st_n.sent = 1'b0;
            if ((line != st_q.line_q || cfg_hit || scan_hit)
                && open_n && line && !st_n.sent) begin
                st_n.sent = 1'b1;
                deliver   = 1'b1;
            end
        end else begin
            if (rej_hit) st_n.rejected = 1'b1;
            // configuration applies before the edge seen in the same cycle
            if (cfg_hit && st_q.held && open_n) begin
                st_n.held = 1'b0;
                deliver   = 1'b1;
            end
            if (line && !st_q.line_q) begin
                if (open_n) deliver   = 1'b1;
                else        st_n.held = 1'b1;
            end
            if (scan_hit && st_n.rejected) begin
                st_n.rejected = 1'b0;
                if (open_n) deliver = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q   <= PRIO_OFF;
            saved_q  <= PRIO_OFF;
            server_q <= '0;
            st_q     <= '0;
            want_q   <= 1'b0;
        end else begin
            prio_q   <= prio_n;
            saved_q  <= saved_n;
            server_q <= server_n;
            st_q     <= st_n;
            want_q   <= (want_q && !issue_hit) || deliver;
        end
    end

    assign want   = want_q;
    assign prio   = prio_q;
    assign saved  = saved_q;
    assign server = server_q;

endmodule

// File: rtl/isc_issue.sv
module isc_issue
    import isc_pkg::*;
#(
    parameter int          N_SRC    = 8,
    parameter int          IDX_W    = 3,
    parameter int          SRC_W    = 16,
    parameter int          SERVER_W = 4,
    parameter int unsigned BASE     = 256
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [N_SRC-1:0]               want,
    input  prio_t [N_SRC-1:0]              prio_vec,
    input  logic [N_SRC-1:0][SERVER_W-1:0] server_vec,
    input  logic                           rsp_ack,
    input  logic                           rsp_nak,
    output logic                           req_valid,
    output logic [IDX_W-1:0]               req_idx,
    output logic [SRC_W-1:0]               req_num,
    output prio_t                          req_prio,
    output logic [SERVER_W-1:0]            req_server,
    output logic [N_SRC-1:0]               issue_hit,
    output logic [N_SRC-1:0]               nak_hit
);

    logic                valid_q;
    logic [IDX_W-1:0]    idx_q, pick;
    logic [SRC_W-1:0]    num_q;
    prio_t               prio_q;
    logic [SERVER_W-1:0] server_q;
    logic                any;

    always_comb begin
        any  = |want;
        pick = IDX_W'(lowest_set(64'(want)));
        issue_hit = '0;
        if (!valid_q && any) issue_hit[pick] = 1'b1;
        nak_hit = '0;
        if (valid_q && rsp_nak) nak_hit[idx_q] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            idx_q    <= '0;
            num_q    <= '0;
            prio_q   <= PRIO_OFF;
            server_q <= '0;
        end else if (valid_q) begin
            if (rsp_ack || rsp_nak) valid_q <= 1'b0;
        end else if (any) begin
            valid_q  <= 1'b1;
            idx_q    <= pick;
            num_q    <= SRC_W'(BASE) + SRC_W'(pick);
            prio_q   <= prio_vec[pick];
            server_q <= server_vec[pick];
        end
    end

    assign req_valid  = valid_q;
    assign req_idx    = idx_q;
    assign req_num    = num_q;
    assign req_prio   = prio_q;
    assign req_server = server_q;

endmodule

// File: rtl/isc_scan.sv
module isc_scan
    import isc_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [N_SRC-1:0] want,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_idx,
    output logic [N_SRC-1:0] scan_hit,
    output logic             busy
);

    scan_st_t         st_q;
    logic [IDX_W-1:0] idx_q;
    logic             slot_busy;

    always_comb begin
        scan_hit = '0;
        if (st_q == SCAN_VISIT) scan_hit[idx_q] = 1'b1;
        slot_busy = want[idx_q] || (req_valid && req_idx == idx_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SCAN_IDLE;
            idx_q <= '0;
        end else begin
            unique case (st_q)
                SCAN_IDLE: if (start) begin
                    st_q  <= SCAN_VISIT;
                    idx_q <= '0;
                end
                SCAN_VISIT: st_q <= SCAN_WAIT;
                SCAN_WAIT: if (!slot_busy) begin
                    if (idx_q == IDX_W'(N_SRC - 1)) begin
                        st_q <= SCAN_IDLE;
                    end else begin
                        st_q  <= SCAN_VISIT;
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: st_q <= SCAN_IDLE;
            endcase
        end
    end

    assign busy = (st_q != SCAN_IDLE);

endmodule

// File: rtl/intr_src_ctl.sv
module intr_src_ctl
    import isc_pkg::*;
#(
    parameter int               N_SRC      = 8,
    parameter int               SRC_W      = 16,
    parameter int               SERVER_W   = 4,
    parameter int unsigned      BASE       = 256,
    parameter logic [N_SRC-1:0] LEVEL_MASK = 8'hF0,
    localparam int              IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_SRC-1:0]    src_line,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [SERVER_W-1:0] cfg_server,
    input  logic [7:0]          cfg_prio,
    input  logic [7:0]          cfg_saved,
    output logic [SERVER_W-1:0] cfg_rd_server,
    output logic [7:0]          cfg_rd_prio,
    output logic [7:0]          cfg_rd_saved,
    input  logic                ntc_valid,
    input  logic                ntc_eoi,
    input  logic [SRC_W-1:0]    ntc_num,
    input  logic                resend_req,
    output logic                req_valid,
    output logic [SRC_W-1:0]    req_num,
    output logic [SERVER_W-1:0] req_server,
    output logic [7:0]          req_prio,
    input  logic                rsp_ack,
    input  logic                rsp_nak,
    output logic                scan_busy
);

    logic [N_SRC-1:0]               want, issue_hit, nak_hit, scan_hit;
    prio_t [N_SRC-1:0]              prio_vec, saved_vec;
    logic [N_SRC-1:0][SERVER_W-1:0] server_vec;
    logic [IDX_W-1:0]               req_idx;
    logic [SRC_W-1:0]               ntc_off;
    logic                           ntc_in;

    // global number to local index
    assign ntc_off = ntc_num - SRC_W'(BASE);
    assign ntc_in  = ntc_valid && (ntc_off < SRC_W'(N_SRC));

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic hit_cfg, hit_ntc;
        assign hit_cfg = cfg_we && (cfg_idx == IDX_W'(g));
        assign hit_ntc = ntc_in && (ntc_off == SRC_W'(g));

        isc_slot #(
            .IS_LEVEL (LEVEL_MASK[g]),
            .SERVER_W (SERVER_W)
        ) u_slot (
            .clk        (clk),
            .rst        (rst),
            .line       (src_line[g]),
            .cfg_hit    (hit_cfg),
            .cfg_server (cfg_server),
            .cfg_prio   (cfg_prio),
            .cfg_saved  (cfg_saved),
            .rej_hit    ((hit_ntc && !ntc_eoi) || nak_hit[g]),
            .eoi_hit    (hit_ntc && ntc_eoi),
            .scan_hit   (scan_hit[g]),
            .issue_hit  (issue_hit[g]),
            .want       (want[g]),
            .prio       (prio_vec[g]),
            .saved      (saved_vec[g]),
            .server     (server_vec[g])
        );
    end

    always_comb begin
        cfg_rd_server = '0;
        cfg_rd_prio   = PRIO_OFF;
        cfg_rd_saved  = PRIO_OFF;
        for (int i = 0; i < N_SRC; i++) begin
            if (cfg_idx == IDX_W'(i)) begin
                cfg_rd_server = server_vec[i];
                cfg_rd_prio   = prio_vec[i];
                cfg_rd_saved  = saved_vec[i];
            end
        end
    end

    isc_issue #(
        .N_SRC    (N_SRC),
        .IDX_W    (IDX_W),
        .SRC_W    (SRC_W),
        .SERVER_W (SERVER_W),
        .BASE     (BASE)
    ) u_issue (
        .clk        (clk),
        .rst        (rst),
        .want       (want),
        .prio_vec   (prio_vec),
        .server_vec (server_vec),
        .rsp_ack    (rsp_ack),
        .rsp_nak    (rsp_nak),
        .req_valid  (req_valid),
        .req_idx    (req_idx),
        .req_num    (req_num),
        .req_prio   (req_prio),
        .req_server (req_server),
        .issue_hit  (issue_hit),
        .nak_hit    (nak_hit)
    );

    isc_scan #(
        .N_SRC (N_SRC),
        .IDX_W (IDX_W)
    ) u_scan (
        .clk       (clk),
        .rst       (rst),
        .start     (resend_req),
        .want      (want),
        .req_valid (req_valid),
        .req_idx   (req_idx),
        .scan_hit  (scan_hit),
        .busy      (scan_busy)
    );

endmodule

// File: rtl/isc_chk.sv
module isc_chk
#(
    parameter int          N_SRC    = 8,
    parameter int          SRC_W    = 16,
    parameter int          SERVER_W = 4,
    parameter int unsigned BASE     = 256
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [SRC_W-1:0]    req_num,
    input logic [7:0]          req_prio,
    input logic [SERVER_W-1:0] req_server,
    input logic                rsp_ack,
    input logic                rsp_nak,
    input logic                resend_req,
    input logic                scan_busy
);

    // R1: nothing pending right after reset
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!req_valid && !scan_busy));

    // R2: requested number within the block's window
    a_r2_num_window: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((req_num >= SRC_W'(BASE)) && (req_num < SRC_W'(BASE + N_SRC))));

    // R3: a masked priority never goes out
    a_r3_no_masked_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_prio != 8'hFF));

    // R10: fields hold until answered
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_ack && !rsp_nak) |=>
            (req_valid && $stable(req_num) && $stable(req_prio) && $stable(req_server)));

    // R10: gap after a response
    a_r10_gap: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (rsp_ack || rsp_nak)) |=> !req_valid);

    // R11: a resend request from idle starts a scan
    a_r11_scan_start: assert property (@(posedge clk) disable iff (rst)
        (resend_req && !scan_busy) |=> scan_busy);

endmodule

bind intr_src_ctl isc_chk #(
    .N_SRC    (N_SRC),
    .SRC_W    (SRC_W),
    .SERVER_W (SERVER_W),
    .BASE     (BASE)
) u_isc_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_num    (req_num),
    .req_prio   (req_prio),
    .req_server (req_server),
    .rsp_ack    (rsp_ack),
    .rsp_nak    (rsp_nak),
    .resend_req (resend_req),
    .scan_busy  (scan_busy)
);

// File: tb/test_intr_src_ctl.sv
`timescale 1ns/1ps
module test_intr_src_ctl;

    localparam int N     = 8;
    localparam int SW    = 16;
    localparam int VW    = 4;
    localparam int BASE  = 256;
    localparam logic [N-1:0] LVL = 8'hF0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  src_line = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [VW-1:0] cfg_server = '0;
    logic [7:0]    cfg_prio = '0, cfg_saved = '0;
    logic [VW-1:0] cfg_rd_server;
    logic [7:0]    cfg_rd_prio, cfg_rd_saved;
    logic          ntc_valid = 1'b0, ntc_eoi = 1'b0;
    logic [SW-1:0] ntc_num = '0;
    logic          resend_req = 1'b0;
    logic          req_valid;
    logic [SW-1:0] req_num;
    logic [VW-1:0] req_server;
    logic [7:0]    req_prio;
    logic          rsp_ack = 1'b0, rsp_nak = 1'b0;
    logic          scan_busy;

    always #5 clk = ~clk;

    intr_src_ctl #(.N_SRC(N), .SRC_W(SW), .SERVER_W(VW), .BASE(BASE), .LEVEL_MASK(LVL))
    i_intr_src_ctl (.*);

    // reference model state
    int    m_prio [N];
    int    m_srv  [N];
    int    m_sav  [N];
    bit    m_line [N], m_sent [N], m_rej [N], m_held [N], m_pend [N];
    bit    nak_mask [N];
    int    vectors = 0, miscompares = 0, cycles = 0;
    string tag = "R1";
    bit    seen = 0;
    int    hold = 0, cur_i = 0;
    int    l_num = 0, l_prio = 0, l_srv = 0;
    bit    done = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic void m_reset();
        for (int i = 0; i < N; i++) begin
            m_prio[i] = 255; m_sav[i] = 255; m_srv[i] = 0;
            m_line[i] = 0; m_sent[i] = 0; m_rej[i] = 0; m_held[i] = 0; m_pend[i] = 0;
        end
    endfunction

    function automatic void m_eval(input int i);
        if (m_prio[i] != 255 && m_line[i] && !m_sent[i]) begin
            m_sent[i] = 1; m_pend[i] = 1;
        end
    endfunction

    function automatic void m_cfg(input int i, input int srv, input int pr, input int sv);
        m_prio[i] = pr; m_srv[i] = srv; m_sav[i] = sv;
        if (LVL[i]) m_eval(i);
        else if (m_held[i] && pr != 255) begin m_held[i] = 0; m_pend[i] = 1; end
    endfunction

    function automatic void m_set_line(input int i, input bit v);
        bit old = m_line[i];
        m_line[i] = v;
        if (LVL[i]) begin
            if (v != old) m_eval(i);
        end else if (v && !old) begin
            if (m_prio[i] == 255) m_held[i] = 1; else m_pend[i] = 1;
        end
    endfunction

    function automatic void m_reject(input int i);
        if (LVL[i]) m_sent[i] = 0; else m_rej[i] = 1;
    endfunction

    function automatic void m_resend();
        for (int i = 0; i < N; i++) begin
            if (LVL[i]) m_eval(i);
            else if (m_rej[i]) begin
                m_rej[i] = 0;
                if (m_prio[i] != 255) m_pend[i] = 1;
            end
        end
    endfunction

    function automatic int pend_count();
        int c = 0;
        for (int i = 0; i < N; i++) c += m_pend[i];
        return c;
    endfunction

    // one clock: clear strobes, compare against the model, answer requests
    task automatic cyc();
        @(posedge clk); #2;
        cycles++;
        cfg_we = 0; ntc_valid = 0; resend_req = 0; rsp_ack = 0; rsp_nak = 0;
        if (req_valid) begin
            if (!seen) begin
                int e = -1;
                for (int i = N - 1; i >= 0; i--) if (m_pend[i]) e = i;
                if (e < 0) begin
                    check(0, tag, "unexpected request", int'(req_num), 0);
                    cur_i = int'(req_num - SW'(BASE)) & (N - 1);
                end else begin
                    check(int'(req_num) == BASE + e, tag, "request number (R2/R11 order)",
                          int'(req_num), BASE + e);
                    check(int'(req_prio) == m_prio[e] && int'(req_server) == m_srv[e], tag,
                          "request prio/server", {req_prio, 4'h0, req_server}, {m_prio[e][7:0], 4'h0, m_srv[e][3:0]});
                    m_pend[e] = 0;
                    cur_i = e;
                end
                seen = 1;
                l_num = req_num; l_prio = req_prio; l_srv = req_server;
                hold = 1 + (cycles % 3);
            end else begin
                check(int'(req_num) == l_num && int'(req_prio) == l_prio && int'(req_server) == l_srv,
                      "R10", "request held stable", int'(req_num), l_num);
            end
            if (hold == 0) begin
                if (nak_mask[cur_i]) begin rsp_nak = 1; m_reject(cur_i); end
                else rsp_ack = 1;
            end else hold--;
        end else begin
            if (seen) check(0, "R10", "request dropped before response", 0, 1);
            seen = 0;
        end
        if (rsp_ack || rsp_nak) seen = 0;
    endtask

    task automatic settle(input string rq);
        int k = 0;
        repeat (4) cyc();
        while (k < 400 && (req_valid || scan_busy || pend_count() != 0)) begin cyc(); k++; end
        repeat (3) cyc();
        check(pend_count() == 0 && !req_valid, rq, "pending deliveries after settle", pend_count(), 0);
    endtask

    task automatic t_cfg(input int i, input int srv, input int pr, input int sv);
        cfg_we = 1; cfg_idx = 3'(i); cfg_server = VW'(srv); cfg_prio = 8'(pr); cfg_saved = 8'(sv);
        m_cfg(i, srv, pr, sv);
        cyc();
    endtask

    task automatic t_lines(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) m_set_line(i, v[i]);
        src_line = v;
        cyc();
    endtask

    task automatic t_ntc(input bit eoi, input int num);
        ntc_valid = 1; ntc_eoi = eoi; ntc_num = SW'(num);
        if (num >= BASE && num < BASE + N) begin
            if (eoi) begin if (LVL[num - BASE]) m_sent[num - BASE] = 0; end
            else m_reject(num - BASE);
        end
        cyc();
    endtask

    task automatic t_resend();
        resend_req = 1;
        m_resend();
        cyc();
    endtask

    task automatic do_reset();
        rst = 1; src_line = '0;
        repeat (3) cyc();
        m_reset();
        rst = 0;
        cyc();
        check(!req_valid && !scan_busy, "R1", "idle after reset", {req_valid, scan_busy}, 0);
        cfg_idx = 3'd5; #1;
        check(cfg_rd_prio == 8'hFF && cfg_rd_saved == 8'hFF && cfg_rd_server == 0, "R1",
              "readback after reset", {cfg_rd_prio, cfg_rd_saved}, 16'hFFFF);
    endtask

    initial begin
        for (int i = 0; i < N; i++) nak_mask[i] = 0;
        m_reset();
        do_reset();

        // R1/R3: edge on masked message source after reset, then resend
        tag = "R1"; t_lines(8'h01); t_resend(); settle("R1");
        tag = "R3"; t_cfg(0, 2, 5, 9); settle("R3");

        // R13: readback
        cfg_idx = 3'd0; #1;
        check(cfg_rd_prio == 8'd5 && cfg_rd_saved == 8'd9 && cfg_rd_server == 4'd2, "R13",
              "readback after write", {cfg_rd_prio, cfg_rd_saved}, 16'h0509);

        // R2: unmasked message edge
        tag = "R2"; t_cfg(1, 1, 3, 3); t_lines(8'h03); settle("R2"); t_lines(8'h00);

        // R3: write FF keeps held, later unmask releases one
        tag = "R3"; t_lines(8'h04); settle("R3"); t_cfg(2, 7, 255, 1); settle("R3");
        t_cfg(2, 7, 7, 1); settle("R3"); t_lines(8'h00);

        // R4: rejected response, then resend
        tag = "R4"; nak_mask[1] = 1; t_lines(8'h02); settle("R4"); nak_mask[1] = 0;
        t_resend(); settle("R4"); t_lines(8'h00);
        t_ntc(0, BASE + 1); t_cfg(1, 1, 255, 3); t_resend(); settle("R4");
        t_cfg(1, 1, 3, 3); t_resend(); settle("R4");

        // R8: EOI to a message source
        tag = "R8"; t_ntc(0, BASE + 1); t_ntc(1, BASE + 1); t_resend(); settle("R8");
        t_resend(); settle("R8");

        // R5: level source
        tag = "R5"; t_cfg(4, 3, 2, 2); t_lines(8'h10); settle("R5");
        t_lines(8'h00); t_lines(8'h10); settle("R5");

        // R6: EOI and reject of a level source
        tag = "R6"; t_ntc(1, BASE + 4); settle("R6"); t_resend(); settle("R6");
        t_ntc(0, BASE + 4); settle("R6"); t_resend(); settle("R6");

        // R9: out-of-window notices
        tag = "R9"; t_ntc(1, BASE + N); t_ntc(0, BASE - 1); t_resend(); settle("R9");

        // R7: unmasking a high level source
        tag = "R7"; t_lines(8'h30); settle("R7"); t_cfg(5, 6, 4, 4); settle("R7");

        // R11: simultaneous edges, then ordered scan with rejects
        tag = "R11"; t_cfg(3, 5, 1, 1); t_cfg(6, 2, 6, 6);
        t_lines(8'h79); settle("R11");
        nak_mask[0] = 1; nak_mask[3] = 1;
        t_lines(8'h70); t_lines(8'h79); settle("R11");
        nak_mask[0] = 0; nak_mask[3] = 0;
        t_ntc(1, BASE + 4); t_ntc(1, BASE + 5); t_ntc(0, BASE + 6);
        t_resend(); settle("R11");

        // R12: unmask write and edge on a held source in one cycle
        tag = "R12"; t_lines(8'h00); t_cfg(2, 7, 255, 1); t_lines(8'h04); t_lines(8'h00); settle("R12");
        cfg_we = 1; cfg_idx = 3'd2; cfg_server = 4'd7; cfg_prio = 8'd7; cfg_saved = 8'd1;
        m_cfg(2, 7, 7, 1);
        src_line = 8'h04; m_set_line(2, 1'b1);
        cyc(); settle("R12");

        // R1: second reset keeps types
        tag = "R1"; t_lines(8'h00); do_reset();
        t_lines(8'h02); settle("R1");
        t_cfg(4, 3, 2, 2); t_lines(8'h12); settle("R1");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000 && !done) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule